// File: doc/BRIEF.md
# Synchronizable Channel Clock Divider Bank

This block is a bank of programmable clock dividers that all run from one fast input clock. Each channel drives an output that stays high for a set number of input cycles and then low for another set number. Because the two counts are set separately, the block can produce any ratio and any duty cycle within the field widths. All channels share one active-low synchronization request. While the request is held, every channel that takes part holds its output at a programmed preset level. When the request is released, each channel starts toggling again after a fixed latency plus its own phase delay. Channels fed from the same clock can therefore be lined up, or skewed against each other, in whole input cycles.

Each channel has a 5-bit phase value. The top bit is the start-high flag and the lower four bits are a coarse offset. The start-high flag selects the preset level and also the direction of the first edge after restart. When the flag is set, the delay also includes the low count. A channel can be excluded from synchronization, and it then free-runs through any request. Settings are copied into the channel only while it is held. Changes made while a channel runs wait for the next synchronization. Leaving reset starts the channels in the same way as releasing a synchronization request.

Top module: `phase_sync_divider`

## Requirements
- R1: While running, a channel's output is high for `hi_len` cycles and low for `lo_len` cycles, with fields of 4 bits at bits [4c+3:4c] for channel c; a field value of 0 behaves as 1.
- R2: While `rst` is high each output equals its `start_hi` bit. After `rst` falls, a channel's first output edge comes at the rising clock edge numbered SYNC_LAT+1+D, where edge 1 is the first edge that samples `rst` low and D is the channel's phase delay.
- R3: From the third rising edge after `sync_n` goes low, and for as long as it stays low, every channel that is not excluded holds its output at its `start_hi` level.
- R4: With `start_hi`=0, the phase delay D equals `ofs`. The first output edge after release comes at rising edge SYNC_LAT+3+D, where edge 1 is the first edge that samples `sync_n` high.
- R5: With `start_hi`=1, the phase delay is D = `ofs` + `lo_len` + 1, and the release timing of R4 applies with this D.
- R6: With `start_hi`=0 the first edge after restart is rising and begins a high phase of `hi_len` cycles. With `start_hi`=1 it is falling and begins a low phase of `lo_len` cycles.
- R7: A channel whose `ignore_sync` bit is 1 keeps toggling with its period unchanged while `sync_n` is low and after it is released.
- R8: Changes to `hi_len`, `lo_len`, `start_hi` or `ofs` made while a channel runs leave its output unchanged. They take effect at the next synchronization.
- R9: Channels with equal ratio and offsets 0, 1 and 2 put their first rising edges 1 and 2 input cycles apart after a common release.
- R10: If `sync_n` goes low again before the restart latency has run out, no output edge occurs, and the timing is counted from the final release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock feeding all dividers |
| rst | input | 1 | Synchronous active-high reset |
| sync_n | input | 1 | Asynchronous active-low synchronization request |
| hi_len | input | 4*NUM_CH | High-phase length per channel, in input cycles |
| lo_len | input | 4*NUM_CH | Low-phase length per channel, in input cycles |
| start_hi | input | NUM_CH | Start-high flag per channel: preset level and restart direction |
| ofs | input | 4*NUM_CH | Coarse phase offset per channel, in input cycles |
| ignore_sync | input | NUM_CH | Excludes the channel from synchronization |
| clk_out | output | NUM_CH | Divided clock outputs |

## Verification
A wrong restart counter or phase delay shows up directly as a first output edge at the wrong cycle, and it is visible within at most about fifty input cycles of release. A wrong phase-length reload shows as a high or low run of the wrong length on the first full period after restart. A settings copy that is not locked shows up within one period as a changed run length on a running channel. A wrong hold or ignore path shows as a toggling output during the request, or as a frozen one, within three cycles of the request going low.

// File: rtl/syncdiv_pkg.sv
package syncdiv_pkg;

    localparam int FLD_W = 4;
    localparam int DLY_W = FLD_W + 2;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } chan_state_e;

    typedef struct packed {
        logic [FLD_W-1:0] hi_len;
        logic [FLD_W-1:0] lo_len;
        logic             start_hi;
        logic [FLD_W-1:0] ofs;
    } chan_cfg_t;

    // Reload value for a phase of f cycles; a zero field acts as one cycle.
    function automatic logic [DLY_W-1:0] phase_reload(input logic [FLD_W-1:0] f);
        return (f == '0) ? '0 : DLY_W'(f) - DLY_W'(1);
    endfunction

    // Restart delay: offset alone, or offset plus low count plus one when start-high.
    function automatic logic [DLY_W-1:0] phase_delay(input chan_cfg_t c);
        logic [DLY_W-1:0] d;
        d = DLY_W'(c.ofs);
        if (c.start_hi)
            d = d + DLY_W'(c.lo_len) + DLY_W'(1);
        return d;
    endfunction

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg <= '1;
        else     stg <= {stg[STAGES-2:0], d_in};
    end

    assign q_out = stg[STAGES-1];
endmodule

// File: rtl/release_timer.sv
module release_timer #(
    parameter int LAT = 14
) (
    input  logic clk,
    input  logic rst,
    input  logic synced_n,
    output logic go
);
    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0] cnt;
    logic          armed;

    assign go = ~rst & synced_n & armed & (cnt == CW'(LAT - 1));

    always_ff @(posedge clk) begin
        if (rst || !synced_n) begin
            cnt   <= '0;
            armed <= 1'b1;
        end else if (armed) begin
            if (cnt == CW'(LAT - 1)) begin
                armed <= 1'b0;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R10: one start pulse per release
    p_single_start_r10: assert property (@(posedge clk) disable iff (rst)
        go |=> !go);
endmodule

// File: rtl/chan_div.sv
module chan_div
    import syncdiv_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sync_act,
    input  logic      go,
    input  logic      ignore,
    input  chan_cfg_t cfg,
    output logic      clk_out
);
    chan_state_e      st;
    chan_cfg_t        held;
    logic [DLY_W-1:0] cnt;
    logic             lvl;
    logic             hold_req;

    assign hold_req = sync_act & ~ignore;

    always_ff @(posedge clk) begin
        if (rst || hold_req) begin
            st   <= ST_HOLD;
            held <= cfg;
            cnt  <= '0;
            lvl  <= cfg.start_hi;
        end else begin
            case (st)
                ST_HOLD: begin
                    held <= cfg;
                    lvl  <= cfg.start_hi;
                    if (go) begin
                        st  <= ST_WAIT;
                        cnt <= phase_delay(cfg);
                    end
                end
                ST_WAIT: begin
                    if (cnt == '0) begin
                        st  <= ST_RUN;
                        lvl <= ~held.start_hi;
                        cnt <= phase_reload(held.start_hi ? held.lo_len : held.hi_len);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_RUN: begin
                    if (cnt == '0) begin
                        lvl <= ~lvl;
                        cnt <= phase_reload(lvl ? held.lo_len : held.hi_len);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: st <= ST_HOLD;
            endcase
        end
    end

    assign clk_out = lvl;

    // R3: a held channel shows the preset level of its start-high bit
    p_freeze_level_r3: assert property (@(posedge clk) disable iff (rst)
        hold_req |=> (clk_out == $past(cfg.start_hi)));

    // R7: an excluded running channel never leaves the run state
    p_ignore_runs_r7: assert property (@(posedge clk) disable iff (rst)
        (ignore && st == ST_RUN) |=> (st == ST_RUN));

    // R1: no edge inside a phase
    p_run_steady_r1: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && cnt != '0 && !hold_req) |=> $stable(clk_out));

    // R4: output stays put during the phase delay
    p_wait_steady_r4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT && cnt != '0 && !hold_req) |=> $stable(clk_out));

    // R6: first edge goes away from the preset level
    p_restart_polarity_r6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT && cnt == '0 && !hold_req) |=> (clk_out != $past(held.start_hi)));

    // R8: captured settings do not move while running
    p_cfg_locked_r8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && !hold_req) |=> $stable(held));
endmodule

// File: rtl/phase_sync_divider.sv
module phase_sync_divider
    import syncdiv_pkg::*;
#(
    parameter int NUM_CH      = 3,
    parameter int SYNC_LAT    = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sync_n,
    input  logic [NUM_CH*FLD_W-1:0] hi_len,
    input  logic [NUM_CH*FLD_W-1:0] lo_len,
    input  logic [NUM_CH-1:0]       start_hi,
    input  logic [NUM_CH*FLD_W-1:0] ofs,
    input  logic [NUM_CH-1:0]       ignore_sync,
    output logic [NUM_CH-1:0]       clk_out
);
    logic synced_n;
    logic sync_act;
    logic go;

    sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (sync_n),
        .q_out (synced_n)
    );

    assign sync_act = ~synced_n;

    release_timer #(.LAT(SYNC_LAT)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .synced_n (synced_n),
        .go       (go)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        chan_cfg_t cfg_c;

        assign cfg_c = '{
            hi_len:   hi_len[c*FLD_W +: FLD_W],
            lo_len:   lo_len[c*FLD_W +: FLD_W],
            start_hi: start_hi[c],
            ofs:      ofs[c*FLD_W +: FLD_W]
        };

        chan_div u_chan (
            .clk      (clk),
            .rst      (rst),
            .sync_act (sync_act),
            .go       (go),
            .ignore   (ignore_sync[c]),
            .cfg      (cfg_c),
            .clk_out  (clk_out[c])
        );
    end
endmodule

// File: tb/phase_sync_divider_bench.sv
`timescale 1ns/1ps
module phase_sync_divider_bench;
    localparam int NCH = 3;
    localparam int LAT = 14;

    typedef struct packed {
        logic [3:0] n;
        logic [3:0] m;
        logic       sh;
        logic [3:0] po;
        int         dly;
        int         l1;
        int         l2;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{4'd4,  4'd4,  1'b0, 4'd0,  0,  4,  4},
        '{4'd2,  4'd3,  1'b0, 4'd5,  5,  2,  3},
        '{4'd3,  4'd5,  1'b1, 4'd0,  6,  5,  3},
        '{4'd1,  4'd1,  1'b1, 4'd2,  4,  1,  1},
        '{4'd15, 4'd1,  1'b0, 4'd15, 15, 15, 1},
        '{4'd1,  4'd15, 1'b1, 4'd15, 31, 15, 1},
        '{4'd0,  4'd2,  1'b0, 4'd3,  3,  1,  2}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sync_n = 1'b1;
    logic [NCH*4-1:0]  hi_len = '0;
    logic [NCH*4-1:0]  lo_len = '0;
    logic [NCH-1:0]    start_hi = '0;
    logic [NCH*4-1:0]  ofs = '0;
    logic [NCH-1:0]    ignore_sync = '0;
    logic [NCH-1:0]    clk_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int fk [NCH];
    int flvl [NCH];
    int len1 [NCH];
    int len2 [NCH];
    int hold_bad [NCH];

    always #2.5 clk = ~clk;

    phase_sync_divider #(.NUM_CH(NCH), .SYNC_LAT(LAT)) u_phase_sync_divider (
        .clk(clk), .rst(rst), .sync_n(sync_n),
        .hi_len(hi_len), .lo_len(lo_len), .start_hi(start_hi),
        .ofs(ofs), .ignore_sync(ignore_sync), .clk_out(clk_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_ch(input int ch, input logic [3:0] n, input logic [3:0] m,
                          input logic sh, input logic [3:0] po);
        hi_len[ch*4 +: 4] = n;
        lo_len[ch*4 +: 4] = m;
        start_hi[ch]      = sh;
        ofs[ch*4 +: 4]    = po;
    endtask

    // Edge 1 is the first rising edge after the call; records first three output changes.
    task automatic measure(input int edges);
        logic prev [NCH];
        int   nchg [NCH];
        int   t [NCH][3];
        for (int ch = 0; ch < NCH; ch++) begin
            prev[ch] = clk_out[ch];
            nchg[ch] = 0;
            flvl[ch] = -1;
            for (int i = 0; i < 3; i++) t[ch][i] = 0;
        end
        for (int k = 1; k <= edges; k++) begin
            @(posedge clk); @(negedge clk);
            for (int ch = 0; ch < NCH; ch++) begin
                if (clk_out[ch] !== prev[ch]) begin
                    if (nchg[ch] < 3) t[ch][nchg[ch]] = k;
                    if (nchg[ch] == 0) flvl[ch] = int'(clk_out[ch]);
                    nchg[ch]++;
                    prev[ch] = clk_out[ch];
                end
            end
        end
        for (int ch = 0; ch < NCH; ch++) begin
            fk[ch]   = t[ch][0];
            len1[ch] = t[ch][1] - t[ch][0];
            len2[ch] = t[ch][2] - t[ch][1];
        end
    endtask

    task automatic run_sync(input int hold);
        @(negedge clk);
        sync_n = 1'b0;
        for (int ch = 0; ch < NCH; ch++) hold_bad[ch] = 0;
        for (int k = 1; k <= hold; k++) begin
            @(posedge clk); @(negedge clk);
            if (k >= 3)
                for (int ch = 0; ch < NCH; ch++)
                    if (!ignore_sync[ch] && clk_out[ch] !== start_hi[ch]) hold_bad[ch]++;
        end
        sync_n = 1'b1;
        measure(110);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int prev_t;
        int bad;
        int nchg;
        int frz;
        logic pv;

        // R2: reset holds preset levels, then restart as from a release
        set_ch(0, 4'd4, 4'd4, 1'b0, 4'd0);
        set_ch(1, 4'd4, 4'd4, 1'b1, 4'd0);
        set_ch(2, 4'd4, 4'd4, 1'b0, 4'd2);
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(clk_out === 3'b010, "R2 reset level", int'(clk_out), 2);
        rst = 1'b0;
        measure(60);
        check(fk[0] == LAT + 1 + 0, "R2 ch0 first edge", fk[0], LAT + 1);
        check(fk[1] == LAT + 1 + 5, "R2 ch1 first edge", fk[1], LAT + 6);
        check(fk[2] == LAT + 1 + 2, "R2 ch2 first edge", fk[2], LAT + 3);

        // Vector table walk on channel 0: R1 R3 R4 R5 R6
        set_ch(1, 4'd4, 4'd4, 1'b0, 4'd0);
        set_ch(2, 4'd4, 4'd4, 1'b0, 4'd0);
        foreach (VECS[i]) begin
            set_ch(0, VECS[i].n, VECS[i].m, VECS[i].sh, VECS[i].po);
            run_sync(6);
            check(hold_bad[0] == 0, "R3 hold level", hold_bad[0], 0);
            if (VECS[i].sh)
                check(fk[0] == LAT + 3 + VECS[i].dly, "R5 release delay", fk[0], LAT + 3 + VECS[i].dly);
            else
                check(fk[0] == LAT + 3 + VECS[i].dly, "R4 release delay", fk[0], LAT + 3 + VECS[i].dly);
            check(flvl[0] == int'(!VECS[i].sh), "R6 first edge direction", flvl[0], int'(!VECS[i].sh));
            check(len1[0] == VECS[i].l1, "R6 first phase length", len1[0], VECS[i].l1);
            check(len2[0] == VECS[i].l2, "R1 second phase length", len2[0], VECS[i].l2);
        end

        // R9: offsets 0,1,2 at ratio 4, 50% duty
        set_ch(0, 4'd2, 4'd2, 1'b0, 4'd0);
        set_ch(1, 4'd2, 4'd2, 1'b0, 4'd1);
        set_ch(2, 4'd2, 4'd2, 1'b0, 4'd2);
        run_sync(6);
        check(fk[1] - fk[0] == 1, "R9 skew ch1", fk[1] - fk[0], 1);
        check(fk[2] - fk[0] == 2, "R9 skew ch2", fk[2] - fk[0], 2);
        check(flvl[0] == 1 && flvl[1] == 1 && flvl[2] == 1, "R9 rising first", flvl[2], 1);

        // R7: excluded channel free-runs through a request
        @(negedge clk);
        ignore_sync[2] = 1'b1;
        sync_n = 1'b0;
        pv = clk_out[2];
        prev_t = -1; bad = 0; nchg = 0; frz = 0;
        for (int k = 1; k <= 80; k++) begin
            @(posedge clk); @(negedge clk);
            if (clk_out[2] !== pv) begin
                if (prev_t >= 0 && k - prev_t != 2) bad++;
                prev_t = k;
                nchg++;
                pv = clk_out[2];
            end
            if (k >= 3 && k <= 30 && clk_out[0] !== 1'b0) frz++;
            if (k == 30) sync_n = 1'b1;
        end
        check(bad == 0, "R7 ignored interval", bad, 0);
        check(nchg >= 35, "R7 ignored toggles", nchg, 40);
        check(frz == 0, "R3 included channel held", frz, 0);

        // R8: on-the-fly changes do not reach a running channel
        @(negedge clk);
        ignore_sync[2] = 1'b0;
        set_ch(0, 4'd5, 4'd3, 1'b1, 4'd7);
        pv = clk_out[0];
        prev_t = -1; bad = 0; nchg = 0;
        for (int k = 1; k <= 40; k++) begin
            @(posedge clk); @(negedge clk);
            if (clk_out[0] !== pv) begin
                if (prev_t >= 0 && k - prev_t != 2) bad++;
                prev_t = k;
                nchg++;
                pv = clk_out[0];
            end
        end
        check(bad == 0 && nchg >= 15, "R8 running ratio kept", bad, 0);
        run_sync(6);
        check(fk[0] == LAT + 3 + 7 + 3 + 1, "R8 new phase at sync", fk[0], LAT + 14);
        check(len1[0] == 3, "R8 new ratio at sync", len1[0], 3);

        // R10: request reasserted inside the restart latency
        set_ch(0, 4'd4, 4'd4, 1'b0, 4'd0);
        @(negedge clk);
        sync_n = 1'b0;
        repeat (6) begin @(posedge clk); @(negedge clk); end
        sync_n = 1'b1;
        frz = 0;
        for (int k = 1; k <= 8; k++) begin
            @(posedge clk); @(negedge clk);
            if (clk_out[0] !== 1'b0) frz++;
        end
        check(frz == 0, "R10 no edge before reassert", frz, 0);
        run_sync(6);
        check(fk[0] == LAT + 3, "R10 timing from final release", fk[0], LAT + 3);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule